// File: doc/BRIEF.md
# Sixteen-bit execute ALU with condition flags

This block is the execute-stage arithmetic unit of a small 16-bit in-order pipeline. It takes the instruction word that sits in the execute stage and two operand values, A and B. In the same cycle it forms a 16-bit result. That result can be an arithmetic, logic or shift value, a load/store address, or a jump target, depending on the 5-bit opcode in instruction bits 15:11.

Three condition flags are held in registers inside the block: carry, zero and negative. They change on a rising clock edge, and only while the pipeline's run input is high. The carry flag feeds the carry-chained add and subtract forms. Immediates and offsets are read straight from the instruction word rather than from the B operand. Every opcode whose two top bits are `11` is a control instruction. No control instruction touches the flags.

Top module: `exu16_alu`

## Requirements
- R1: ADD (01000), SUB (01011) and CMP (01100) produce A+B, A-B and A-B; ADDC (10001) produces A+B+carry and SUBC (10111) produces A-B-carry. Each writes the carry flag with the adder's carry-out, or with the borrow for the subtract forms.
- R2: ADDI (01001) and SUBI (10011) use instruction bits 7:0, zero-extended, in place of B. Carry is written as for R1.
- R3: LDIH (10000) produces A plus a value whose upper byte is instruction bits 7:0 and whose lower byte is zero. Carry takes the carry-out.
- R4: AND (01101), OR (01111) and XOR (01110) produce the bitwise result and clear the carry flag.
- R5: Shifts take their amount from bits 3:0: SLL (00100) shifts left, SLA (00101) shifts left exactly like SLL, SRL (00110) shifts right logically, and SRA (00111) shifts right arithmetically. Carry takes the last bit shifted out.
- R6: A shift by 0 returns A unchanged and leaves the carry flag as it was.
- R7: LOAD (00010) and STORE (00011) produce A plus bits 3:0, zero-extended, and leave carry alone. LOAD also leaves zero and negative; STORE updates them.
- R8: JUMP (11000) yields bits 7:0, zero-extended. Any other opcode 11xxx yields A plus bits 7:0, zero-extended. No control opcode alters any flag.
- R9: For the opcodes of R1 to R6 and for STORE, zero is set exactly when the result is 0 and negative copies result bit 15.
- R10: Flags change only on a rising edge with run high. With run low, all three hold.
- R11: A synchronous active-high reset clears all three flags.
- R12: NOP (00000), HALT (00001) and every opcode not named above yield 0 and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| run | input | 1 | High while the pipeline executes; enables flag updates |
| instr | input | 16 | Instruction word held in the execute stage |
| opnd_a | input | 16 | First operand (A) |
| opnd_b | input | 16 | Second operand (B) |
| result | output | 16 | Combinational result, address or target |
| flag_c | output | 1 | Carry flag register |
| flag_z | output | 1 | Zero flag register |
| flag_n | output | 1 | Negative flag register |

## Verification
The result is combinational, so it is due in the same cycle as its inputs. The flags are due one rising edge later. The bench changes inputs on the falling edge and reads the result one time unit afterwards. It reads the flags one time unit after the following rising edge. The vector table runs in sequence, so the carry left by one vector feeds the next carry-chained vector. The expected flags of held-flag opcodes are the values the previous vector left behind.

// File: rtl/exu16_pkg.sv
package exu16_pkg;

  localparam int OPC_W = 5;

  localparam logic [4:0] OPC_NOP   = 5'b00000;
  localparam logic [4:0] OPC_HALT  = 5'b00001;
  localparam logic [4:0] OPC_LD    = 5'b00010;
  localparam logic [4:0] OPC_ST    = 5'b00011;
  localparam logic [4:0] OPC_SHL   = 5'b00100;
  localparam logic [4:0] OPC_SHLA  = 5'b00101;
  localparam logic [4:0] OPC_SHR   = 5'b00110;
  localparam logic [4:0] OPC_SHRA  = 5'b00111;
  localparam logic [4:0] OPC_ADD   = 5'b01000;
  localparam logic [4:0] OPC_ADDK  = 5'b01001;
  localparam logic [4:0] OPC_SUB   = 5'b01011;
  localparam logic [4:0] OPC_CMP   = 5'b01100;
  localparam logic [4:0] OPC_AND   = 5'b01101;
  localparam logic [4:0] OPC_XOR   = 5'b01110;
  localparam logic [4:0] OPC_OR    = 5'b01111;
  localparam logic [4:0] OPC_HIADD = 5'b10000;
  localparam logic [4:0] OPC_ADDCY = 5'b10001;
  localparam logic [4:0] OPC_SUBK  = 5'b10011;
  localparam logic [4:0] OPC_SUBCY = 5'b10111;
  localparam logic [4:0] OPC_JMPA  = 5'b11000;
  localparam logic [1:0] CTRL_PFX  = 2'b11;

  typedef enum logic [2:0] {RS_ZERO, RS_SUM, RS_AND, RS_OR, RS_XOR, RS_SHIFT, RS_IMM} rsel_e;
  typedef enum logic [1:0] {YS_OPB, YS_IMMLO, YS_IMMHI, YS_OFS} ysel_e;
  typedef enum logic [1:0] {SK_LEFT, SK_RLOG, SK_RARI} shk_e;
  typedef enum logic [1:0] {CS_HOLD, CS_ADDER, CS_CLEAR, CS_SHIFT} csrc_e;

  typedef struct packed {
    rsel_e rsel;
    ysel_e ysel;
    logic  sub;
    logic  cin_en;
    shk_e  shk;
    csrc_e csrc;
    logic  zn_en;
  } ctl_t;

endpackage

// File: rtl/exu16_dec.sv
module exu16_dec
  import exu16_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctl_t             ctl
);

  always_comb begin
    ctl = '{rsel: RS_ZERO, ysel: YS_OPB, sub: 1'b0, cin_en: 1'b0,
            shk: SK_LEFT, csrc: CS_HOLD, zn_en: 1'b0};
    if (opc[OPC_W-1 -: 2] == CTRL_PFX) begin
      ctl.ysel = YS_IMMLO;
      ctl.rsel = (opc == OPC_JMPA) ? RS_IMM : RS_SUM;
    end else begin
      case (opc)
        OPC_ADD, OPC_ADDCY, OPC_SUB, OPC_SUBCY, OPC_CMP: begin
          ctl.rsel   = RS_SUM;
          ctl.sub    = (opc == OPC_SUB) || (opc == OPC_SUBCY) || (opc == OPC_CMP);
          ctl.cin_en = (opc == OPC_ADDCY) || (opc == OPC_SUBCY);
          ctl.csrc   = CS_ADDER;
          ctl.zn_en  = 1'b1;
        end
        OPC_ADDK, OPC_SUBK: begin
          ctl.rsel  = RS_SUM;
          ctl.ysel  = YS_IMMLO;
          ctl.sub   = (opc == OPC_SUBK);
          ctl.csrc  = CS_ADDER;
          ctl.zn_en = 1'b1;
        end
        OPC_HIADD: begin
          ctl.rsel  = RS_SUM;
          ctl.ysel  = YS_IMMHI;
          ctl.csrc  = CS_ADDER;
          ctl.zn_en = 1'b1;
        end
        OPC_AND, OPC_OR, OPC_XOR: begin
          ctl.rsel  = (opc == OPC_AND) ? RS_AND : ((opc == OPC_OR) ? RS_OR : RS_XOR);
          ctl.csrc  = CS_CLEAR;
          ctl.zn_en = 1'b1;
        end
        OPC_SHL, OPC_SHLA, OPC_SHR, OPC_SHRA: begin
          ctl.rsel  = RS_SHIFT;
          ctl.shk   = (opc == OPC_SHR) ? SK_RLOG : ((opc == OPC_SHRA) ? SK_RARI : SK_LEFT);
          ctl.csrc  = CS_SHIFT;
          ctl.zn_en = 1'b1;
        end
        OPC_LD, OPC_ST: begin
          ctl.rsel  = RS_SUM;
          ctl.ysel  = YS_OFS;
          ctl.zn_en = (opc == OPC_ST);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/exu16_addsub.sv
module exu16_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout
);

  logic [DW:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
    else     ext = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  end

  assign sum  = ext[DW-1:0];
  assign cout = ext[DW];

endmodule

// File: rtl/exu16_shift.sv
module exu16_shift
  import exu16_pkg::*;
#(
  parameter int DW  = 16,
  localparam int SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  val,
  input  logic [SHW-1:0] amt,
  input  shk_e           kind,
  output logic [DW-1:0]  res,
  output logic           cout
);

  logic [DW:0]        left_ext;
  logic [DW:0]        rlog_ext;
  logic signed [DW:0] rari_src;
  logic signed [DW:0] rari_ext;

  assign left_ext = {1'b0, val} << amt;
  assign rlog_ext = {val, 1'b0} >> amt;
  assign rari_src = {val, 1'b0};
  assign rari_ext = rari_src >>> amt;

  always_comb begin
    case (kind)
      SK_RLOG: begin res = rlog_ext[DW:1]; cout = rlog_ext[0]; end
      SK_RARI: begin res = rari_ext[DW:1]; cout = rari_ext[0]; end
      default: begin res = left_ext[DW-1:0]; cout = left_ext[DW]; end
    endcase
  end

endmodule

// File: rtl/exu16_flagreg.sv
module exu16_flagreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          upd_c,
  input  logic          c_nxt,
  input  logic          upd_zn,
  input  logic [DW-1:0] res,
  output logic          fc,
  output logic          fz,
  output logic          fn
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fc <= 1'b0;
      fz <= 1'b0;
      fn <= 1'b0;
    end else if (run) begin
      if (upd_c) fc <= c_nxt;
      if (upd_zn) begin
        fz <= (res == '0);
        fn <= res[DW-1];
      end
    end
  end

endmodule

// File: rtl/exu16_alu.sv
module exu16_alu
  import exu16_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IW    = 16,
  parameter int IMM_W = 8,
  parameter int OFS_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] result,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n
);

  localparam int SHW     = $clog2(DW);
  localparam int OPC_LSB = IW - OPC_W;

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;
  logic [OFS_W-1:0] ofs;
  logic [SHW-1:0]   amt;
  logic             unused_regsel;
  ctl_t             ctl;

  logic [DW-1:0] add_y, add_sum, sh_res;
  logic          add_co, sh_co, c_upd, c_nxt;

  assign opc           = instr[IW-1:OPC_LSB];
  assign imm           = instr[IMM_W-1:0];
  assign ofs           = instr[OFS_W-1:0];
  assign amt           = instr[SHW-1:0];
  assign unused_regsel = ^instr[OPC_LSB-1:IMM_W];

  exu16_dec u_dec (.opc(opc), .ctl(ctl));

  always_comb begin
    case (ctl.ysel)
      YS_IMMLO: add_y = DW'(imm);
      YS_IMMHI: add_y = {imm, {(DW-IMM_W){1'b0}}};
      YS_OFS:   add_y = DW'(ofs);
      default:  add_y = opnd_b;
    endcase
  end

  exu16_addsub #(.DW(DW)) u_add (
    .x(opnd_a), .y(add_y), .cin(ctl.cin_en & flag_c), .sub(ctl.sub),
    .sum(add_sum), .cout(add_co)
  );

  exu16_shift #(.DW(DW)) u_shf (
    .val(opnd_a), .amt(amt), .kind(ctl.shk), .res(sh_res), .cout(sh_co)
  );

  always_comb begin
    case (ctl.rsel)
      RS_SUM:   result = add_sum;
      RS_AND:   result = opnd_a & opnd_b;
      RS_OR:    result = opnd_a | opnd_b;
      RS_XOR:   result = opnd_a ^ opnd_b;
      RS_SHIFT: result = (amt == '0) ? opnd_a : sh_res;
      RS_IMM:   result = DW'(imm);
      default:  result = '0;
    endcase
  end

  always_comb begin
    case (ctl.csrc)
      CS_ADDER: begin c_upd = 1'b1;         c_nxt = add_co; end
      CS_CLEAR: begin c_upd = 1'b1;         c_nxt = 1'b0;   end
      CS_SHIFT: begin c_upd = (amt != '0);  c_nxt = sh_co;  end
      default:  begin c_upd = 1'b0;         c_nxt = 1'b0;   end
    endcase
  end

  exu16_flagreg #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .run(run),
    .upd_c(c_upd), .c_nxt(c_nxt), .upd_zn(ctl.zn_en), .res(result),
    .fc(flag_c), .fz(flag_z), .fn(flag_n)
  );

endmodule

// File: rtl/exu16_alu_chk.sv
module exu16_alu_chk
  import exu16_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic [IW-1:0] instr,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] result,
  input logic          flag_c,
  input logic          flag_z,
  input logic          flag_n
);

  logic [OPC_W-1:0] opc;
  logic is_ctrl, is_logic, is_shift, zn_op, unused_lo;

  assign opc       = instr[IW-1 -: OPC_W];
  assign is_ctrl   = opc[OPC_W-1 -: 2] == CTRL_PFX;
  assign is_logic  = opc inside {OPC_AND, OPC_OR, OPC_XOR};
  assign is_shift  = opc inside {OPC_SHL, OPC_SHLA, OPC_SHR, OPC_SHRA};
  assign zn_op     = is_logic || is_shift ||
                     (opc inside {OPC_ADD, OPC_ADDCY, OPC_SUB, OPC_SUBCY, OPC_CMP,
                                  OPC_ADDK, OPC_SUBK, OPC_HIADD, OPC_ST});
  assign unused_lo = ^instr[IW-OPC_W-1:8];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable({flag_c, flag_z, flag_n})); // R10

  AST_LOGIC_CLR: assert property (@(posedge clk) disable iff (rst)
    run && is_logic |=> !flag_c); // R4

  AST_ZERO_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    run && zn_op |=> flag_z == ($past(result) == '0)); // R9

  AST_NEG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    run && zn_op |=> flag_n == $past(result[DW-1])); // R9

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
    run && is_ctrl |=> $stable({flag_c, flag_z, flag_n})); // R8

  AST_SH0_CARRY: assert property (@(posedge clk) disable iff (rst)
    run && is_shift && instr[3:0] == 4'd0 |=> $stable(flag_c)); // R6

  always_comb begin
    if (!rst && is_shift && instr[3:0] == 4'd0)
      AST_SH0_PASS: assert (result == opnd_a); // R6
    if (!rst && opc == OPC_JMPA)
      AST_JUMP_TGT: assert (result == DW'(instr[7:0])); // R8
  end

endmodule

bind exu16_alu exu16_alu_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .instr(instr), .opnd_a(opnd_a),
  .result(result), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n)
);

// File: tb/tb_exu16_alu.sv
module tb_exu16_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;

  typedef struct packed {
    logic [15:0] ir, a, b, res;
    logic c, z, n;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{16'h4312, 16'hfc00, 16'h00ab, 16'hfcab, 1'b0, 1'b0, 1'b1},
    '{16'h5b12, 16'hfc00, 16'h00ab, 16'hfb55, 1'b0, 1'b0, 1'b1},
    '{16'h6321, 16'h00ab, 16'hfc00, 16'h04ab, 1'b1, 1'b0, 1'b0},
    '{16'h8b12, 16'hfc00, 16'h00ab, 16'hfcac, 1'b0, 1'b0, 1'b1},
    '{16'h4000, 16'hffff, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'h8800, 16'h0001, 16'h0001, 16'h0003, 1'b0, 1'b0, 1'b0},
    '{16'h5800, 16'h0000, 16'h0001, 16'hffff, 1'b1, 1'b0, 1'b1},
    '{16'hb800, 16'h0005, 16'h0002, 16'h0002, 1'b0, 1'b0, 1'b0},
    '{16'hb800, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
    '{16'h4810, 16'hfff0, 16'h1234, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'h9806, 16'h0005, 16'h1234, 16'hffff, 1'b1, 1'b0, 1'b1},
    '{16'h8012, 16'h0034, 16'h5678, 16'h1234, 1'b0, 1'b0, 1'b0},
    '{16'h8001, 16'hff00, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'h6800, 16'hf0f0, 16'hff00, 16'hf000, 1'b0, 1'b0, 1'b1},
    '{16'h4000, 16'hffff, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{16'h7000, 16'haaaa, 16'h5555, 16'hffff, 1'b0, 1'b0, 1'b1},
    '{16'h7800, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
    '{16'h2001, 16'hfb55, 16'h0000, 16'hf6aa, 1'b1, 1'b0, 1'b1},
    '{16'h3001, 16'hfc00, 16'h0000, 16'h7e00, 1'b0, 1'b0, 1'b0},
    '{16'h2801, 16'hfc00, 16'h0000, 16'hf800, 1'b1, 1'b0, 1'b1},
    '{16'h3801, 16'hfc00, 16'h0000, 16'hfe00, 1'b0, 1'b0, 1'b1},
    '{16'h300f, 16'hc001, 16'h0000, 16'h0001, 1'b1, 1'b0, 1'b0},
    '{16'h200f, 16'h0003, 16'h0000, 16'h8000, 1'b1, 1'b0, 1'b1},
    '{16'h3000, 16'h1234, 16'h0000, 16'h1234, 1'b1, 1'b0, 1'b0},
    '{16'h3804, 16'h8000, 16'h0000, 16'hf800, 1'b0, 1'b0, 1'b1},
    '{16'h3800, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0},
    '{16'h11f5, 16'h0010, 16'hffff, 16'h0015, 1'b0, 1'b1, 1'b0},
    '{16'h1b03, 16'hfff0, 16'h0000, 16'hfff3, 1'b0, 1'b0, 1'b1},
    '{16'hc0a5, 16'h1234, 16'h0000, 16'h00a5, 1'b0, 1'b0, 1'b1},
    '{16'hd010, 16'h0030, 16'h0000, 16'h0040, 1'b0, 1'b0, 1'b1},
    '{16'hf8ff, 16'hff01, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{16'h0000, 16'h8000, 16'h7777, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{16'h0800, 16'h8000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{16'h5000, 16'h1111, 16'h2222, 16'h0000, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [15:0] result;
  logic        flag_c, flag_z, flag_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exu16_alu dut (
    .clk(clk), .rst(rst), .run(run), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n)
  );

  function automatic string tag_of(logic [15:0] ir);
    logic [4:0] op = ir[15:11];
    if (op[4:3] == 2'b11) return "R8";
    case (op)
      5'b01000, 5'b10001, 5'b01011, 5'b10111, 5'b01100: return "R1";
      5'b01001, 5'b10011: return "R2";
      5'b10000: return "R3";
      5'b01101, 5'b01111, 5'b01110: return "R4";
      5'b00100, 5'b00101, 5'b00110, 5'b00111: return (ir[3:0] == 4'd0) ? "R6" : "R5";
      5'b00010, 5'b00011: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(string req, logic c, logic z, logic n);
    check(req, "carry", 16'(flag_c), 16'(c));
    check({req, "/R9"}, "zero", 16'(flag_z), 16'(z));
    check({req, "/R9"}, "negative", 16'(flag_n), 16'(n));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_flags("R11", 1'b0, 1'b0, 1'b0);      // R11 reset state
    @(negedge clk);
    rst = 1'b0;
    run = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr  = VEC[i].ir;
      opnd_a = VEC[i].a;
      opnd_b = VEC[i].b;
      #1;
      check(tag_of(VEC[i].ir), "result", result, VEC[i].res);
      @(posedge clk);
      #1;
      check_flags(tag_of(VEC[i].ir), VEC[i].c, VEC[i].z, VEC[i].n);
    end

    // R10: run low, an add that would set carry and zero leaves flags
    @(negedge clk);
    run    = 1'b0;
    instr  = 16'h4000;
    opnd_a = 16'hffff;
    opnd_b = 16'h0001;
    #1;
    check("R1", "result idle", result, 16'h0000);
    @(posedge clk);
    #1;
    check_flags("R10", 1'b0, 1'b0, 1'b1);

    // set all nonzero flags, then R11 reset mid-run clears them
    @(negedge clk);
    run    = 1'b1;
    instr  = 16'h5800;
    opnd_a = 16'h0000;
    opnd_b = 16'h0001;
    @(posedge clk);
    #1;
    check_flags("R1", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_flags("R11", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    run = 1'b0;
    @(posedge clk);
    #1;
    finish_run();
  end

endmodule